// File: doc/BRIEF.md
# Enclosure Indication Register Block

This block is the device-side register set of a native enclosure-management extended capability. Software reaches it through a simple 32-bit configuration port addressed by dword offset. Four words are visible: a capability header, a capability word that advertises the supported indications, a control word, and a status word. The block drives one output line for each indication that is currently applied.

Every write to the control word is a command, including a write that repeats the current value. The written value is held as pending. A two-state machine (`ST_IDLE`, `ST_WAIT`) counts a programmable delay. When the count ends, the pending value is filtered and applied, and command-completed is set in the status word. The filter drops three kinds of bits: unsupported ones, reserved ones, and those removed by an elaboration-time conflict rule. A reset command clears every indication. A read of the control word always returns the value that was actually applied, not the value that was written.

The state machine has these transitions:
- `CMD_START`: from `ST_IDLE` to `ST_WAIT` on any control write.
- `CMD_RESTART`: from `ST_WAIT` to `ST_WAIT` on a control write; the counter reloads.
- `CMD_TICK`: from `ST_WAIT` to `ST_WAIT` while the counter is non-zero.
- `CMD_APPLY`: from `ST_WAIT` to `ST_IDLE` when the counter is zero and no write arrives in that cycle.

Top module: `encl_ind_regs`

## Requirements
- R1: A read at dword offset 0 returns the capability header 0x00010029: ID 0x0029 in bits 15:0, version 1 in bits 19:16, and a next pointer of 0 in bits 31:20.
- R2: A read at dword offset 1 returns the capability word. Bit 0 (capable) is always 1. The other bits are the supported-feature mask, limited to bit 1 (reset), bits 2..11 and bits 24..31.
- R3: Control (dword offset 2) and status (dword offset 3) behave as follows after a control write sampled at edge e0:
  - the control read value and the indication outputs keep their old value through edge e0+DELAY-1;
  - the new applied value appears after edge e0+DELAY;
  - status bit 0 (command completed) sets after that same edge.
- R4: A control write made while a command is still waiting restarts the delay with the new value. The earlier value is never applied.
- R5: A control write that repeats the current applied value is still a command and sets command completed again.
- R6: Command completed is cleared in three ways:
  - writing status with bit 0 = 1 clears it;
  - writing status with bit 0 = 0 leaves it unchanged;
  - any control write clears it.
- R7: In the applied control value, bit 0 is enable and indication bits sit at 2..11 (bit 2 OK, bit 3 Locate, bit 4 Fail, bit 5 Rebuild, bits 6..11 the remaining standard indications) and 24..31 (enclosure-specific). Unsupported bits and reserved bits (12..23) always read as zero.
- R8: While applied enable (bit 0) is clear, all indication outputs are 0. While it is set, output bit k equals applied control bit k for every indication position k, and all other output bits are 0.
- R9: Applying a command with bit 1 (reset) set, when reset is supported, clears all indication bits. Enable takes the written value, and bit 1 reads back as 0.
- R10: With the Fail-over-OK rule (RULE = 1), applying a command that requests both Fail (bit 4) and OK (bit 2) drops OK and keeps Fail.
- R11: Reads at any dword offset other than 0..3 return zero.
- R12: After reset, control, status and all indication outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | ADDR_W | Dword offset within the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| ind_o | output | 32 | Indication drive lines, one per control-word position |

## Verification
The bench builds the block with a supported mask of 0xBF000F7F, DELAY = 5 and RULE = 1. That mask leaves Hot Spare (bit 7) and specific bit 30 unsupported while supporting reset, so dropped bits, self-clearing reset and the Fail-over-OK conflict can all be reached in one build. A delay of five cycles leaves room to probe the control word before it is applied and to land a second write inside the waiting window. Random control words checked against a bench model then exercise the filter across many mixes of enable, reserved, specific and conflicting bits.

// File: rtl/encl_pkg.sv
package encl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cmd_state_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_RST  = 1;
    localparam int BIT_OK   = 2;
    localparam int BIT_FAIL = 4;
    localparam int BIT_DIS  = 11;

    localparam int RULE_NONE         = 0;
    localparam int RULE_FAIL_OVER_OK = 1;
    localparam int RULE_DIS_ALONE    = 2;

    localparam logic [31:0] IND_MASK  = 32'hFF00_0FFC;
    localparam logic [31:0] FEAT_MASK = 32'hFF00_0FFE;

    localparam logic [15:0] HDR_ID  = 16'h0029;
    localparam logic [3:0]  HDR_VER = 4'h1;

    localparam int OFS_HDR = 0;
    localparam int OFS_CAP = 1;
    localparam int OFS_CTL = 2;
    localparam int OFS_STS = 3;
endpackage

// File: rtl/encl_cmd_fsm.sv
module encl_cmd_fsm
    import encl_pkg::*;
#(
    parameter int DELAY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    output logic apply_o,
    output logic busy_o
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    cmd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cmd_wr) begin
            state_d = ST_WAIT;
            cnt_d   = LOAD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WAIT: begin
                    if (cnt_q == '0) state_d = ST_IDLE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        apply_o = 1'b0;
        busy_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                busy_o  = 1'b1;
                apply_o = (cnt_q == '0) && !cmd_wr;
            end
            default: ;
        endcase
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (state_q == ST_WAIT && cnt_q == LOAD));

    assert_idle_after_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> state_q == ST_IDLE);
endmodule

// File: rtl/encl_apply.sv
module encl_apply
    import encl_pkg::*;
#(
    parameter logic [31:0] SUPPORT = 32'hFF00_0FFE,
    parameter int          RULE    = RULE_FAIL_OVER_OK
) (
    input  logic [31:0] raw_i,
    output logic [31:0] applied_o
);
    localparam logic [31:0] WMASK = 32'h1 | (SUPPORT & FEAT_MASK);

    logic [31:0] kept;
    logic [31:0] resolved;

    assign kept = raw_i & WMASK;

    generate
        if (RULE == RULE_FAIL_OVER_OK) begin : g_fail_over_ok
            always_comb begin
                resolved = kept;
                if (kept[BIT_FAIL]) resolved[BIT_OK] = 1'b0;
            end
        end else if (RULE == RULE_DIS_ALONE) begin : g_dis_alone
            always_comb begin
                resolved = kept;
                if (kept[BIT_DIS]) resolved = kept & ((32'h1 << BIT_DIS) | 32'h1);
            end
        end else begin : g_no_rule
            assign resolved = kept;
        end
    endgenerate

    always_comb begin
        if (resolved[BIT_RST]) applied_o = resolved & 32'h1;
        else                   applied_o = resolved;
    end
endmodule

// File: rtl/encl_ind_drive.sv
module encl_ind_drive
    import encl_pkg::*;
(
    input  logic [31:0] ctrl_i,
    output logic [31:0] ind_o
);
    always_comb begin
        if (ctrl_i[BIT_EN]) ind_o = ctrl_i & IND_MASK;
        else                ind_o = '0;
    end
endmodule

// File: rtl/encl_ind_regs.sv
module encl_ind_regs
    import encl_pkg::*;
#(
    parameter int          ADDR_W  = 10,
    parameter logic [31:0] SUPPORT = 32'hFF00_0FFE,
    parameter int          DELAY   = 5,
    parameter int          RULE    = RULE_FAIL_OVER_OK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [31:0]       ind_o
);
    localparam logic [31:0] CAP_WORD = 32'h1 | (SUPPORT & FEAT_MASK);
    localparam logic [31:0] HDR_WORD = {12'h000, HDR_VER, HDR_ID};

    logic        ctl_wr, sts_wr;
    logic        apply, busy;
    logic [31:0] pend_q, ctrl_q, applied;
    logic        cc_q;

    assign ctl_wr = cfg_wr && (cfg_addr == ADDR_W'(OFS_CTL));
    assign sts_wr = cfg_wr && (cfg_addr == ADDR_W'(OFS_STS));

    encl_cmd_fsm #(.DELAY(DELAY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (ctl_wr),
        .apply_o (apply),
        .busy_o  (busy)
    );

    encl_apply #(.SUPPORT(SUPPORT), .RULE(RULE)) u_apply (
        .raw_i     (pend_q),
        .applied_o (applied)
    );

    encl_ind_drive u_drive (
        .ctrl_i (ctrl_q),
        .ind_o  (ind_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            ctrl_q <= '0;
            cc_q   <= 1'b0;
        end else begin
            if (ctl_wr) pend_q <= cfg_wdata;
            if (apply)  ctrl_q <= applied;
            if (apply)                        cc_q <= 1'b1;
            else if (ctl_wr)                  cc_q <= 1'b0;
            else if (sts_wr && cfg_wdata[0])  cc_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            ADDR_W'(OFS_HDR): cfg_rdata = HDR_WORD;
            ADDR_W'(OFS_CAP): cfg_rdata = CAP_WORD;
            ADDR_W'(OFS_CTL): cfg_rdata = ctrl_q;
            ADDR_W'(OFS_STS): cfg_rdata = {31'b0, cc_q};
            default:          cfg_rdata = '0;
        endcase
    end

    assert_ctrl_on_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(apply));

    assert_cc_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_q) |-> $past(apply) && $past(busy));

    assert_cc_clear_on_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !apply) |=> !cc_q);

    assert_dark_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[BIT_EN] |-> ind_o == '0);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_q[BIT_RST] && SUPPORT[BIT_RST]) |=> (ctrl_q & IND_MASK) == '0);

    generate
        if (RULE == RULE_FAIL_OVER_OK) begin : g_chk_rule
            assert_fail_over_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q[BIT_FAIL] |-> !ctrl_q[BIT_OK]);
        end
    endgenerate
endmodule

// File: tb/test_encl_ind_regs.sv
`timescale 1ns/1ps
module test_encl_ind_regs;
    localparam int          AW    = 10;
    localparam logic [31:0] SUP   = 32'hBF00_0F7F;
    localparam int          DLY   = 5;
    localparam logic [31:0] WM    = 32'h1 | (SUP & 32'hFF00_0FFE);
    localparam logic [31:0] INDM  = 32'hFF00_0FFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata, ind_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    encl_ind_regs #(.ADDR_W(AW), .SUPPORT(SUP), .DELAY(DLY), .RULE(1)) i_encl_ind_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ind_o(ind_o)
    );

    function automatic logic [31:0] model_apply(input logic [31:0] w);
        logic [31:0] m;
        m = w & WM;
        if (m[4]) m[2] = 1'b0;
        if (m[1]) m = m & 32'h1;
        return m;
    endfunction

    function automatic logic [31:0] model_ind(input logic [31:0] c);
        return c[0] ? (c & INDM) : 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        cfg_addr = AW'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w, e;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        rd(2, d); chk("R12 ctrl", d, 32'h0);
        rd(3, d); chk("R12 status", d, 32'h0);
        chk("R12 ind", ind_o, 32'h0);
        rd(0, d); chk("R1 header", d, 32'h0001_0029);
        rd(1, d); chk("R2 capability", d, SUP);
        rd(5, d); chk("R11 offset 5", d, 32'h0);
        rd(1023, d); chk("R11 offset 1023", d, 32'h0);

        // R3 delay and visibility
        wr(2, 32'h0000_000D);
        idle(DLY - 1);
        rd(3, d); chk("R3 cc early", d, 32'h0);
        rd(2, d); chk("R3 ctrl early", d, 32'h0);
        chk("R3 ind early", ind_o, 32'h0);
        idle(1);
        rd(3, d); chk("R3 cc set", d, 32'h1);
        rd(2, d); chk("R3 ctrl applied", d, 32'h0000_000D);
        chk("R8 ind enabled", ind_o, 32'h0000_000C);

        // R6 write-1-to-clear
        wr(3, 32'h0);
        rd(3, d); chk("R6 w0 no effect", d, 32'h1);
        wr(3, 32'h1);
        rd(3, d); chk("R6 w1 clears", d, 32'h0);

        // R5 repeat write is a command
        wr(2, 32'h0000_000D);
        idle(DLY - 1);
        rd(3, d); chk("R5 cc early", d, 32'h0);
        idle(1);
        rd(3, d); chk("R5 cc again", d, 32'h1);
        rd(2, d); chk("R5 ctrl same", d, 32'h0000_000D);

        // R4 restart, R6 control write clears cc
        wr(2, 32'h0000_0021);
        rd(3, d); chk("R6 ctl write clears cc", d, 32'h0);
        idle(2);
        wr(2, 32'h0000_0009);
        idle(DLY - 1);
        rd(2, d); chk("R4 no early apply", d, 32'h0000_000D);
        rd(3, d); chk("R4 cc held", d, 32'h0);
        idle(1);
        rd(2, d); chk("R4 second value", d, 32'h0000_0009);

        // R8 enable clear
        wr(2, 32'h0000_000C);
        idle(DLY);
        rd(2, d); chk("R8 ctrl disabled", d, 32'h0000_000C);
        chk("R8 dark", ind_o, 32'h0);

        // R7 filtering, R10 conflict
        wr(2, 32'hFFFF_FFFD);
        idle(DLY);
        rd(2, d); chk("R7 filtered", d, 32'hBF00_0F79);
        chk("R7 ind", ind_o, 32'hBF00_0F78);

        // R9 reset command
        wr(2, 32'h0000_0003);
        idle(DLY);
        rd(2, d); chk("R9 reset clears", d, 32'h1);
        chk("R9 ind", ind_o, 32'h0);
        wr(2, 32'h0000_0012);
        idle(DLY);
        rd(2, d); chk("R9 reset no enable", d, 32'h0);

        // R10 Fail over OK
        wr(2, 32'h0000_0015);
        idle(DLY);
        rd(2, d); chk("R10 fail drops ok", d, 32'h0000_0011);
        chk("R10 ind", ind_o, 32'h0000_0010);

        // Random commands against model (R7, R8, R10)
        for (int i = 0; i < 60; i++) begin
            w = $urandom();
            if (i % 4 == 0) w = w & ~32'h2;
            e = model_apply(w);
            wr(2, w);
            idle(DLY);
            rd(2, d); chk("R7 random ctrl", d, e);
            chk("R8 random ind", ind_o, model_ind(e));
            rd(3, d); chk("R3 random cc", d, 32'h1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule